// File: doc/BRIEF.md
# Ternary Programmable Logic Unit

This unit applies a caller-selected ternary logic function to whole words of balanced-ternary digits. Each digit takes the value -1 (written i), 0 or +1. The function is not fixed in hardware. It arrives with every request as a small truth table of trits, normally an immediate field of the instruction that invokes the unit. The same table is applied separately at every digit position of the word.

Two modes are available. In the single-operand mode, a three-entry table maps each digit of operand A. In the two-operand mode, a nine-entry table maps each pair of digits drawn from operands A and B. Each output digit is chosen from the table by a multiplexer, with no arithmetic on the path. Any table made of valid trits is accepted, so all 3^9 = 19683 two-input functions can be reached.

Each accepted request produces its result word, an error flag and a valid strobe one clock later. Malformed digit codes in the operands or in the used part of the table raise the error flag.

Top module: `tern_lut_unit`

## Requirements
- R1: Every trit travels on two wires: 2'b11 is -1, 2'b00 is 0 and 2'b01 is +1. Trit k of a word sits at bits [2k+1:2k]. The code 2'b10 never appears in a result word.
- R2: In single-operand mode (`op_binary` = 0), table entries at bits [1:0], [3:2] and [5:4] give the result for an operand A trit of -1, 0 and +1 respectively.
- R3: In single-operand mode, the table (-1, 0, +1) returns operand A unchanged, and the table (+1, -1, 0) maps -1 to +1, 0 to -1 and +1 to 0.
- R4: In two-operand mode, the result trit is table entry e = 3*(a+1) + (b+1), located at bits [2e+1:2e]. Here a and b are the trit values of operands A and B at the same position.
- R5: Any of the 19683 tables built from valid trits is accepted and gives the result set out in R4, with the error flag low.
- R6: Every trit position uses the same table, and the result at one position depends only on the operand trits at that position.
- R7: An operand trit coded 2'b10 sets the error flag and yields a 0 result at that position, while the other positions are computed normally. Operand B is ignored in single-operand mode, including its invalid codes.
- R8: A table entry coded 2'b10 sets the error flag when it lies in the used part of the table: entries 0 to 2 in single-operand mode, and all nine entries in two-operand mode. A result trit that selects such an entry is 0. Entries 3 to 8 have no effect in single-operand mode.
- R9: `out_valid` is high in the cycle after a cycle with `in_valid` high. `out_word` and `out_err` then hold that request's result. Back-to-back requests give back-to-back results.
- R10: While `in_valid` is low, `out_word` and `out_err` keep their last values, whatever the other inputs do.
- R11: A synchronous active-high reset clears `out_valid`, `out_word` and `out_err` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_binary | input | 1 | 0 selects single-operand mode, 1 selects two-operand mode |
| lut_trits | input | 18 | Truth table, nine trits, entry e at bits [2e+1:2e] |
| opnd_a | input | 2*TRITS | Operand A word |
| opnd_b | input | 2*TRITS | Operand B word, used only in two-operand mode |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_word | output | 2*TRITS | Registered result word |
| out_err | output | 1 | Registered flag for malformed operand or table codes |

## Verification
The bench builds the unit with the default width of nine trits. That width matches the nine entries of a two-operand table. One request whose operand A is (i,i,i,0,0,0,1,1,1) and whose operand B is (i,0,1) repeated therefore visits every entry at once, and the result word must reproduce the table itself. The same width leaves room to corrupt one position while its neighbours are still checked, which exposes any leak between positions.

// File: rtl/tern_lut_unit.sv
module tern_lut_unit #(
  parameter int TRITS = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 op_binary,
  input  logic [17:0]          lut_trits,
  input  logic [2*TRITS-1:0]   opnd_a,
  input  logic [2*TRITS-1:0]   opnd_b,
  output logic                 out_valid,
  output logic [2*TRITS-1:0]   out_word,
  output logic                 out_err
);

  localparam int W = 2 * TRITS;
  localparam int ENTRIES = 9;

  function automatic logic [1:0] slot_of(input logic [1:0] code);
    case (code)
      2'b11:   slot_of = 2'd0;
      2'b00:   slot_of = 2'd1;
      2'b01:   slot_of = 2'd2;
      default: slot_of = 2'd3;
    endcase
  endfunction

  logic [ENTRIES-1:0] ent_ok;
  logic [TRITS-1:0]   pos_bad;
  logic [W-1:0]       res_word;
  logic               lut_bad;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign ent_ok[e] = lut_trits[2*e+1 -: 2] != 2'b10;
  end

  assign lut_bad = op_binary ? ~&ent_ok : ~&ent_ok[2:0];

  for (genvar t = 0; t < TRITS; t++) begin : g_pos
    logic [1:0] sa, sb;
    logic [3:0] idx;
    logic [1:0] pick;
    assign sa = slot_of(opnd_a[2*t+1 -: 2]);
    assign sb = slot_of(opnd_b[2*t+1 -: 2]);
    assign pos_bad[t] = (sa == 2'd3) || (op_binary && sb == 2'd3);
    always_comb begin
      idx = op_binary ? ({2'b00, sa} * 4'd3 + {2'b00, sb}) : {2'b00, sa};
      if (pos_bad[t]) idx = 4'd0;
      pick = lut_trits[2*idx +: 2];
      if (pos_bad[t] || pick == 2'b10) pick = 2'b00;
    end
    assign res_word[2*t+1 -: 2] = pick;

    // R1
    out_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_word[2*t+1 -: 2] != 2'b10);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word <= res_word;
        out_err  <= lut_bad | (|pos_bad);
      end
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_word) && $stable(out_err)));

  // R3
  identity_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_binary && lut_trits[5:0] == 6'b01_00_11 && !(|pos_bad))
      |=> (out_word == $past(opnd_a) && !out_err));

endmodule

// File: tb/tern_lut_unit_tb.sv
module tern_lut_unit_tb_top;
  localparam int TRITS = 9;
  localparam int W = 2 * TRITS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic op_binary = 1'b0;
  logic [17:0] lut_trits = '0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic out_valid;
  logic [W-1:0] out_word;
  logic out_err;

  int checks = 0;
  int errors = 0;
  bit armed = 0;
  bit done = 0;
  string cur_req = "R11";
  string exp_req = "R11";
  logic exp_v;
  logic [W-1:0] exp_w;
  logic exp_e;

  always #5 clk = ~clk;

  tern_lut_unit #(.TRITS(TRITS)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_binary(op_binary),
    .lut_trits(lut_trits), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_valid(out_valid), .out_word(out_word), .out_err(out_err)
  );

  function automatic logic [1:0] enc(input int v);
    return (v < 0) ? 2'b11 : (v > 0) ? 2'b01 : 2'b00;
  endfunction

  function automatic int dec(input logic [1:0] c, output bit bad);
    bad = 0;
    if (c == 2'b11) return -1;
    if (c == 2'b01) return 1;
    if (c == 2'b00) return 0;
    bad = 1;
    return 0;
  endfunction

  function automatic logic [17:0] mk_lut(input int v[9]);
    logic [17:0] r = '0;
    for (int e = 0; e < 9; e++) r[2*e +: 2] = enc(v[e]);
    return r;
  endfunction

  function automatic logic [W-1:0] mk_word(input int v[TRITS]);
    logic [W-1:0] r = '0;
    for (int t = 0; t < TRITS; t++) r[2*t +: 2] = enc(v[t]);
    return r;
  endfunction

  function automatic logic [W-1:0] rnd_word();
    logic [W-1:0] r = '0;
    for (int t = 0; t < TRITS; t++) r[2*t +: 2] = enc(int'($urandom % 3) - 1);
    return r;
  endfunction

  function automatic logic [17:0] rnd_lut();
    logic [17:0] r = '0;
    for (int e = 0; e < 9; e++) r[2*e +: 2] = enc(int'($urandom % 3) - 1);
    return r;
  endfunction

  // behavioural reference, evaluated on the sampled request
  always @(posedge clk) begin
    if (rst) begin
      exp_v = 0; exp_w = '0; exp_e = 0; exp_req = "R11";
    end else begin
      exp_v = in_valid;
      if (in_valid) begin
        int used;
        bit any_bad;
        exp_req = cur_req;
        used = op_binary ? 9 : 3;
        any_bad = 0;
        for (int e = 0; e < used; e++) if (lut_trits[2*e +: 2] == 2'b10) any_bad = 1;
        for (int t = 0; t < TRITS; t++) begin
          bit ba, bb;
          int va, vb, e, ov;
          bit eb;
          va = dec(opnd_a[2*t +: 2], ba);
          vb = dec(opnd_b[2*t +: 2], bb);
          if (!op_binary) bb = 0;
          if (ba || bb) begin
            any_bad = 1;
            exp_w[2*t +: 2] = 2'b00;
          end else begin
            e = op_binary ? 3 * (va + 1) + (vb + 1) : va + 1;
            ov = dec(lut_trits[2*e +: 2], eb);
            exp_w[2*t +: 2] = enc(ov);
          end
        end
        exp_e = any_bad;
      end
    end
    armed = 1;
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      checks++;
      if (out_valid !== exp_v || out_word !== exp_w || out_err !== exp_e) begin
        errors++;
        $display("FAIL %s: valid/word/err got %b/%h/%b expected %b/%h/%b",
                 exp_req, out_valid, out_word, out_err, exp_v, exp_w, exp_e);
      end
      checks++;
      for (int t = 0; t < TRITS; t++) begin
        if (out_word[2*t +: 2] == 2'b10) begin
          errors++;
          $display("FAIL R1: trit %0d got code 10 expected a legal code", t);
        end
      end
    end
  end

  task automatic issue(input string req, input bit bin, input logic [17:0] lut,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    cur_req = req;
    in_valid = 1; op_binary = bin; lut_trits = lut; opnd_a = a; opnd_b = b;
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur_req = req;
      in_valid = 0;
      op_binary = $urandom % 2; lut_trits = rnd_lut();
      opnd_a = rnd_word(); opnd_b = rnd_word();
    end
  endtask

  task automatic finish_up();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_up();
  end

  initial begin
    int ta[TRITS];
    int tb[TRITS];
    logic [W-1:0] w;
    logic [17:0] l;
    // R11: reset state observed by the per-cycle compare
    repeat (3) @(negedge clk);
    rst = 0;
    idle(2, "R10");

    // R3 identity and the rotating map
    for (int i = 0; i < 4; i++) issue("R3", 0, mk_lut('{-1, 0, 1, 0, 0, 0, 0, 0, 0}), rnd_word(), rnd_word());
    for (int i = 0; i < 4; i++) issue("R3", 0, mk_lut('{1, -1, 0, 1, 1, 1, 1, 1, 1}), rnd_word(), rnd_word());
    // R2 arbitrary single-operand tables
    for (int i = 0; i < 10; i++) issue("R2", 0, rnd_lut(), rnd_word(), rnd_word());
    idle(1, "R9");

    // R4 every entry visited in one word: result equals the table
    for (int t = 0; t < TRITS; t++) begin
      ta[t] = (t / 3) - 1;
      tb[t] = (t % 3) - 1;
    end
    for (int i = 0; i < 6; i++) issue("R4", 1, rnd_lut(), mk_word(ta), mk_word(tb));
    issue("R4", 1, mk_lut('{-1, -1, -1, -1, 0, 0, -1, 0, 1}), mk_word(ta), mk_word(tb));
    // R5 random functions over random words
    for (int i = 0; i < 40; i++) issue("R5", 1, rnd_lut(), rnd_word(), rnd_word());
    // R6 uniform A word with varied B, and the reverse
    for (int t = 0; t < TRITS; t++) ta[t] = 1;
    issue("R6", 1, rnd_lut(), mk_word(ta), rnd_word());
    issue("R6", 1, rnd_lut(), rnd_word(), mk_word(ta));

    // R7 bad operand codes at one position
    for (int p = 0; p < TRITS; p += 4) begin
      w = rnd_word(); w[2*p +: 2] = 2'b10;
      issue("R7", 1, rnd_lut(), w, rnd_word());
      issue("R7", 1, rnd_lut(), rnd_word(), w);
      issue("R7", 0, rnd_lut(), w, rnd_word());
      issue("R7", 0, rnd_lut(), rnd_word(), w);
    end
    // R8 bad table entries, used and unused
    for (int e = 0; e < 9; e++) begin
      l = rnd_lut(); l[2*e +: 2] = 2'b10;
      issue("R8", 1, l, mk_word(ta), rnd_word());
      issue("R8", 0, l, rnd_word(), rnd_word());
    end
    // R10 hold across idle cycles with noisy inputs
    issue("R10", 1, rnd_lut(), rnd_word(), rnd_word());
    idle(5, "R10");
    // R9 alternate gaps and bursts
    for (int i = 0; i < 6; i++) begin
      issue("R9", i % 2, rnd_lut(), rnd_word(), rnd_word());
      if (i % 3 == 0) idle(1, "R9");
    end
    idle(2, "R9");
    // R11 reset in the middle of traffic
    issue("R11", 1, rnd_lut(), rnd_word(), rnd_word());
    @(negedge clk);
    in_valid = 1; rst = 1; cur_req = "R11";
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    rst = 0;
    idle(2, "R11");
    finish_up();
  end
endmodule